// File: doc/BRIEF.md
# USB Host Channel Interrupt Aggregator

This block gathers interrupt events from eight USB host channels and presents them to software in three tiers. Each channel has an 11-bit status word. It latches one-cycle event pulses from that channel's transfer logic:

- transfer complete
- channel halted
- STALL, NAK and ACK responses
- transaction error
- babble
- frame overrun
- data toggle error

Software clears a status bit by writing a one to it.

Above the channel words sits a pending-channel summary word with one bit per channel. Above that is a single global bit, which also drives the interrupt output. Both upper tiers are computed from the tier below them, so they need no clear of their own. When a channel's last set bit is cleared, its summary bit and the global bit drop in the same cycle.

Software services an interrupt in three steps. It reads the summary word to find a pending channel. It then reads that channel's status word. Finally it writes back the bits it has handled. The register port is a plain address/write-enable/write-data bus with combinational read data.

Top module: `hch_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, every channel status word, the summary word and the global bit read as zero and `irq` is low.
- R2: Channel x (0 to 7) status word is read and written at address 0x508 + 0x20·x. The field positions are: bit 0 transfer done, bit 1 halted, bit 3 STALL, bit 4 NAK, bit 5 ACK, bit 7 transaction error, bit 8 babble, bit 9 frame overrun, bit 10 toggle error.
- R3: An event pulse on a channel sets its status bit at the next clock edge. A pulse on a bit that is already set leaves it set.
- R4: Bit 7 sets when any of the four error pulses for that channel is high: CRC failure, timeout, bit-stuff error or false end-of-packet.
- R5: Writing 1 to a defined status bit clears it. Writing 0 leaves it unchanged.
- R6: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: Bits 31:11, 6 and 2 of a channel status word always read as zero, even after writing all ones or pulsing every event.
- R8: The summary word at address 0x414 has bit x set exactly while channel x has any status bit set. Writes to it have no effect.
- R9: The global word at address 0x400 has bit 0 set while any summary bit is set, and `irq` equals that bit. Writes to it have no effect.
- R10: Clearing a channel's last set bits clears its summary bit, and the global bit and `irq` if no other channel is pending, with no further write.
- R11: A write or event on one channel leaves every other channel's status word unchanged.
- R12: Reads of any address that is not a channel word, 0x414 or 0x400 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wen | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data (ones clear status bits) |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ev_xfer_done | input | 8 | Per-channel transfer complete pulse |
| ev_halted | input | 8 | Per-channel halted pulse |
| ev_stall | input | 8 | Per-channel STALL received pulse |
| ev_nak | input | 8 | Per-channel NAK received pulse |
| ev_ack | input | 8 | Per-channel ACK pulse |
| ev_crc_err | input | 8 | Per-channel CRC failure pulse |
| ev_timeout | input | 8 | Per-channel timeout pulse |
| ev_stuff_err | input | 8 | Per-channel bit-stuff error pulse |
| ev_false_eop | input | 8 | Per-channel false end-of-packet pulse |
| ev_babble | input | 8 | Per-channel babble pulse |
| ev_frm_overrun | input | 8 | Per-channel frame overrun pulse |
| ev_toggle_err | input | 8 | Per-channel data toggle error pulse |
| irq | output | 1 | Interrupt request, equal to the global bit |

## Verification
The embedded assertions check on every cycle that:
- a pulsed bit is set one edge later, which also covers the set-wins race;
- a write of ones clears and a write of zeros preserves;
- at most one channel word is decoded at a time;
- reserved positions read zero whenever a channel word is addressed;
- a summary bit rises only after an event on its channel;
- the global bit falls only after a write.

Only the bench scenarios can show the following:
- the exact address map, including the holes between channel words;
- that writes to the summary and global words are ignored;
- that each of the four error sources reaches bit 7;
- that traffic on one channel leaves the other seven intact.

// File: rtl/hch_irq_pkg.sv
// Shared field layout of a host channel status word.
// Assumes an 11-bit word; positions 2 and 6 are unused.
package hch_irq_pkg;
    localparam int STAT_W   = 11;
    localparam int B_XFER   = 0;
    localparam int B_HALT   = 1;
    localparam int B_STALL  = 3;
    localparam int B_NAK    = 4;
    localparam int B_ACK    = 5;
    localparam int B_TXN    = 7;
    localparam int B_BABBLE = 8;
    localparam int B_FRMOVR = 9;
    localparam int B_TOGGLE = 10;
    // Mask of defined positions (bits 2 and 6 clear).
    localparam logic [STAT_W-1:0] DEF_MASK = 11'h7BB;
endpackage

// File: rtl/hch_chan_status.sv
// One channel's write-one-to-clear status word.
// Assumes event bits arrive already placed in their field positions.
// A set and a clear of the same bit in one cycle resolve to set.
module hch_chan_status
    import hch_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev_bits,
    input  logic              wr_hit,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] stat
);
    logic [STAT_W-1:0] clr;
    logic [STAT_W-1:0] set;

    // Derive the clear and set vectors, restricted to defined positions.
    always_comb begin
        clr = wr_hit ? (wr_data & DEF_MASK) : '0;
        set = ev_bits & DEF_MASK;
    end

    // Update the status word: clear first, then set, so that set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr) | set;
    end

    // R3, R6: every pulsed bit is set one edge later, even under a clearing write.
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((stat & $past(set)) == $past(set)));

    // R5: with no event present, written ones end up clear.
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr != '0) && (set == '0)) |=> ((stat & $past(clr)) == '0));

    // R5: with no event present, bits not written with a one keep their value.
    a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (set == '0) |=> ((stat & ~$past(clr)) == ($past(stat) & ~$past(clr))));
endmodule

// File: rtl/hch_irq_summary.sv
// Upper two tiers: a per-channel pending bit and one global bit.
// Both are pure OR reductions of the tier below, so they carry no state.
module hch_irq_summary
    import hch_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCH-1:0][STAT_W-1:0]  stat_all,
    input  logic [NCH-1:0]              ev_any,
    input  logic                        wr_any,
    output logic [NCH-1:0]              sum,
    output logic                        glob
);
    for (genvar c = 0; c < NCH; c++) begin : g_sum
        // Flag channel c as pending while any of its status bits is set.
        assign sum[c] = |stat_all[c];

        // R8: a channel becomes pending only after an event on that channel.
        a_r8_sum_rises_on_event: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sum[c]) |-> $past(ev_any[c]));
    end

    // Raise the global bit while any channel is pending.
    assign glob = |sum;

    // R10: the global bit can only fall as the result of a write.
    a_r10_glob_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(glob) |-> $past(wr_any));
endmodule

// File: rtl/hch_bus_decode.sv
// Address decode and read-data mux for the register port.
// Assumes NCH does not exceed DATA_W and that the addresses do not overlap.
module hch_bus_decode
    import hch_irq_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int CH_BASE   = 'h508,
    parameter int CH_STRIDE = 'h20,
    parameter int SUM_ADDR  = 'h414,
    parameter int GLB_ADDR  = 'h400
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wen,
    input  logic [NCH-1:0][STAT_W-1:0]  stat_all,
    input  logic [NCH-1:0]              sum,
    input  logic                        glob,
    output logic [NCH-1:0]              wr_hit,
    output logic [DATA_W-1:0]           rdata
);
    localparam logic [ADDR_W-1:0] SUM_A = ADDR_W'(SUM_ADDR);
    localparam logic [ADDR_W-1:0] GLB_A = ADDR_W'(GLB_ADDR);

    logic [NCH-1:0] ch_hit;

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        localparam logic [ADDR_W-1:0] CH_A = ADDR_W'(CH_BASE + c * CH_STRIDE);
        // Match the address of channel c and gate its write strobe.
        assign ch_hit[c] = (addr == CH_A);
        assign wr_hit[c] = wen & ch_hit[c];
    end

    // Select the read data of whichever register the address names.
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++)
            if (ch_hit[c]) rdata[STAT_W-1:0] = stat_all[c];
        if (addr == SUM_A) rdata[NCH-1:0] = sum;
        if (addr == GLB_A) rdata[0] = glob;
    end

    // R2: no address selects more than one channel word.
    a_r2_onehot_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_hit));

    // R7: reserved positions of a channel word never reach the bus.
    a_r7_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_hit) |-> ((rdata & ~DATA_W'(DEF_MASK)) == '0));
endmodule

// File: rtl/hch_irq_agg.sv
// Top of the host channel interrupt aggregator.
// Maps per-type event pulses into per-channel status words, builds the
// summary tiers and serves the register port. Assumes one-cycle pulses.
module hch_irq_agg
    import hch_irq_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int CH_BASE   = 'h508,
    parameter int CH_STRIDE = 'h20,
    parameter int SUM_ADDR  = 'h414,
    parameter int GLB_ADDR  = 'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    ev_xfer_done,
    input  logic [NCH-1:0]    ev_halted,
    input  logic [NCH-1:0]    ev_stall,
    input  logic [NCH-1:0]    ev_nak,
    input  logic [NCH-1:0]    ev_ack,
    input  logic [NCH-1:0]    ev_crc_err,
    input  logic [NCH-1:0]    ev_timeout,
    input  logic [NCH-1:0]    ev_stuff_err,
    input  logic [NCH-1:0]    ev_false_eop,
    input  logic [NCH-1:0]    ev_babble,
    input  logic [NCH-1:0]    ev_frm_overrun,
    input  logic [NCH-1:0]    ev_toggle_err,
    output logic              irq
);
    logic [NCH-1:0][STAT_W-1:0] stat_all;
    logic [NCH-1:0]             wr_hit;
    logic [NCH-1:0]             ev_any;
    logic [NCH-1:0]             sum;
    logic                       glob;
    logic                       unused_wdata_hi;

    // Upper write-data bits have no storage behind them.
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:STAT_W];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [STAT_W-1:0] evb;

        // Place channel c's pulses in their field positions; four error sources share bit 7.
        always_comb begin
            evb           = '0;
            evb[B_XFER]   = ev_xfer_done[c];
            evb[B_HALT]   = ev_halted[c];
            evb[B_STALL]  = ev_stall[c];
            evb[B_NAK]    = ev_nak[c];
            evb[B_ACK]    = ev_ack[c];
            evb[B_TXN]    = ev_crc_err[c] | ev_timeout[c] | ev_stuff_err[c] | ev_false_eop[c];
            evb[B_BABBLE] = ev_babble[c];
            evb[B_FRMOVR] = ev_frm_overrun[c];
            evb[B_TOGGLE] = ev_toggle_err[c];
        end

        // Flag any event on channel c for the summary checker.
        assign ev_any[c] = |evb;

        hch_chan_status u_stat (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_bits (evb),
            .wr_hit  (wr_hit[c]),
            .wr_data (bus_wdata[STAT_W-1:0]),
            .stat    (stat_all[c])
        );
    end

    hch_irq_summary #(.NCH(NCH)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_all (stat_all),
        .ev_any   (ev_any),
        .wr_any   (|wr_hit),
        .sum      (sum),
        .glob     (glob)
    );

    hch_bus_decode #(
        .NCH       (NCH),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CH_BASE   (CH_BASE),
        .CH_STRIDE (CH_STRIDE),
        .SUM_ADDR  (SUM_ADDR),
        .GLB_ADDR  (GLB_ADDR)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wen      (bus_wen),
        .stat_all (stat_all),
        .sum      (sum),
        .glob     (glob),
        .wr_hit   (wr_hit),
        .rdata    (bus_rdata)
    );

    // Drive the interrupt line straight from the global bit.
    assign irq = glob;
endmodule

// File: tb/sim_hch_irq_agg.sv
// Self-checking bench: a vector table walked by one loop, then directed cases.
module sim_hch_irq_agg;
    localparam logic [10:0] DEF = 11'h7BB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  ev_xfer_done = '0, ev_halted = '0, ev_stall = '0, ev_nak = '0;
    logic [7:0]  ev_ack = '0, ev_crc_err = '0, ev_timeout = '0, ev_stuff_err = '0;
    logic [7:0]  ev_false_eop = '0, ev_babble = '0, ev_frm_overrun = '0, ev_toggle_err = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [10:0] expv [8];

    always #10 clk = ~clk;

    hch_irq_agg u0 (.*);

    typedef struct packed {
        logic [2:0]  ech;
        logic [10:0] emask;
        logic        wen;
        logic [2:0]  wch;
        logic [31:0] wdat;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 11'h001, 1'b0, 3'd0, 32'h0},          // R3 set xfer ch0
        '{3'd3, 11'h018, 1'b0, 3'd0, 32'h0},          // R3 stall+nak ch3
        '{3'd7, 11'h780, 1'b0, 3'd0, 32'h0},          // R3 upper fields ch7
        '{3'd0, 11'h000, 1'b1, 3'd0, 32'h1},          // R5 clear ch0
        '{3'd3, 11'h008, 1'b1, 3'd5, 32'hFFFF_FFFF},  // R3 re-pulse, R11 write idle ch5
        '{3'd5, 11'h023, 1'b1, 3'd3, 32'h10},         // R11 clear nak ch3 only
        '{3'd5, 11'h001, 1'b1, 3'd5, 32'h1},          // R6 race ch5
        '{3'd0, 11'h000, 1'b1, 3'd7, 32'h0},          // R5 zero write keeps
        '{3'd0, 11'h000, 1'b1, 3'd7, 32'h380},        // R5 partial clear
        '{3'd1, 11'h002, 1'b1, 3'd1, 32'h2},          // R6 race ch1
        '{3'd0, 11'h000, 1'b1, 3'd3, 32'h7FF},        // R10 ch3 empty
        '{3'd0, 11'h000, 1'b1, 3'd5, 32'hFFFF},       // R10 ch5 empty
        '{3'd0, 11'h000, 1'b1, 3'd7, 32'h400},        // R10 ch7 empty
        '{3'd0, 11'h000, 1'b1, 3'd1, 32'h2}           // R10 all empty
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_ev(input int ch, input logic [10:0] m, input int src);
        ev_xfer_done[ch]   = m[0];
        ev_halted[ch]      = m[1];
        ev_stall[ch]       = m[3];
        ev_nak[ch]         = m[4];
        ev_ack[ch]         = m[5];
        ev_crc_err[ch]     = m[7] && src == 0;
        ev_timeout[ch]     = m[7] && src == 1;
        ev_stuff_err[ch]   = m[7] && src == 2;
        ev_false_eop[ch]   = m[7] && src == 3;
        ev_babble[ch]      = m[8];
        ev_frm_overrun[ch] = m[9];
        ev_toggle_err[ch]  = m[10];
    endtask

    task automatic clr_ev();
        {ev_xfer_done, ev_halted, ev_stall, ev_nak, ev_ack, ev_crc_err} = '0;
        {ev_timeout, ev_stuff_err, ev_false_eop, ev_babble, ev_frm_overrun, ev_toggle_err} = '0;
    endtask

    // Apply one cycle of events and/or a write, and update the model.
    task automatic step(input int ech, input logic [10:0] em, input int src,
                        input logic wen, input logic [11:0] wa, input logic [31:0] wd);
        @(negedge clk);
        set_ev(ech, em, src);
        bus_wen = wen; bus_addr = wa; bus_wdata = wd;
        @(negedge clk);
        clr_ev();
        bus_wen = 1'b0; bus_wdata = '0;
        for (int c = 0; c < 8; c++)
            if (wen && wa == 12'(12'h508 + c * 32)) expv[c] &= ~(wd[10:0] & DEF);
        expv[ech] |= em & DEF;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        logic [7:0]  es;
        es = '0;
        for (int c = 0; c < 8; c++) begin
            rd(12'(12'h508 + c * 32), d);
            chk($sformatf("R2 R3 R5 R6 R7 R11 %s ch%0d", tag, c), d, {21'b0, expv[c]});
            es[c] = (expv[c] != 0);
        end
        rd(12'h414, d);
        chk({"R8 R10 summary ", tag}, d, {24'b0, es});
        rd(12'h400, d);
        chk({"R9 R10 global ", tag}, d, {31'b0, |es});
        chk({"R9 irq ", tag}, {31'b0, irq}, {31'b0, |es});
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] d;
        for (int c = 0; c < 8; c++) expv[c] = '0;
        // R1: events during reset must not survive it.
        ev_xfer_done = 8'hFF;
        ev_toggle_err = 8'hFF;
        repeat (3) @(negedge clk);
        clr_ev();
        rst_n = 1'b1;
        check_all("R1 reset");

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].ech, VEC[i].emask, 0, VEC[i].wen,
                 12'(12'h508 + VEC[i].wch * 32), VEC[i].wdat);
            check_all($sformatf("vec%0d", i));
        end

        // R4: each error source alone reaches bit 7, then a write clears it.
        for (int s = 0; s < 4; s++) begin
            step(2, 11'h080, s, 1'b0, 12'h0, 32'h0);
            rd(12'h548, d);
            chk($sformatf("R4 src%0d", s), d, 32'h80);
            step(0, 11'h000, 0, 1'b1, 12'h548, 32'h80);
            rd(12'h548, d);
            chk($sformatf("R4 R5 clear src%0d", s), d, 32'h0);
        end
        expv[2] = '0;

        // R7 and R2: every input pulsed lands on defined bits only.
        @(negedge clk);
        ev_xfer_done[4] = 1; ev_halted[4] = 1; ev_stall[4] = 1; ev_nak[4] = 1;
        ev_ack[4] = 1; ev_crc_err[4] = 1; ev_timeout[4] = 1; ev_stuff_err[4] = 1;
        ev_false_eop[4] = 1; ev_babble[4] = 1; ev_frm_overrun[4] = 1; ev_toggle_err[4] = 1;
        @(negedge clk);
        clr_ev();
        rd(12'h588, d);
        chk("R7 all events ch4", d, 32'h7BB);
        expv[4] = 11'h7BB;

        // R8, R9: writes to the summary and global words change nothing.
        step(0, 11'h000, 0, 1'b1, 12'h414, 32'hFFFF_FFFF);
        step(0, 11'h000, 0, 1'b1, 12'h400, 32'hFFFF_FFFF);
        check_all("R8 R9 ignored writes");

        // R12: holes and out-of-range addresses read zero.
        rd(12'h50C, d); chk("R12 hole 0x50C", d, 32'h0);
        rd(12'h000, d); chk("R12 addr 0x000", d, 32'h0);
        rd(12'h608, d); chk("R12 past ch7", d, 32'h0);

        // R10: clearing ch4 drops the summary, global bit and irq together.
        step(0, 11'h000, 0, 1'b1, 12'h588, 32'h7BB);
        expv[4] = '0;
        check_all("R10 final clear");
        chk("R10 irq low", {31'b0, irq}, 32'h0);

        report();
    end
endmodule